// File: doc/BRIEF.md
# Stereo ADC Output Conditioning Filter

This block sits after the decimation chain of a stereo audio converter and conditions each pair of signed PCM samples before they leave the converter. Two things are applied to each channel. The first is an optional high-pass filter that removes DC and low-frequency content. The second is an optional sign inversion, which comes after the filter. Both channels share one arithmetic unit. The left sample is worked first and the right sample second, and a one-cycle valid pulse marks the finished pair three cycles after the pair was accepted.

A 9-bit control word selects the behaviour. It holds the filter enable, the filter mode and a 3-bit cutoff code. It also holds the two polarity bits and an oversampling-ratio bit, which the block only stores and drives out to the modulator. The filter has two modes:
- a fixed first-order DC blocker for normal audio capture;
- a second-order high-pass for application use, whose coefficients come from a table indexed by the cutoff code and by a sample-rate group derived from a 3-bit rate input.

Whenever a control write alters the enable, the mode or the cutoff code, the filter history is wiped. This keeps stale state from producing a transient.

Top module: `adc_hpf_cond`

## Requirements
- R1: After reset `cfg_q` reads 9'h100 (filter on, audio mode, cutoff code 000, both polarities normal, oversampling bit 0), `osr_128` is 0, `out_valid` is 0 and both output samples are 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the control word, visible on `cfg_q` in the next cycle. Bit 2 always reads 0, and no other cycle changes `cfg_q`. `osr_128` follows control bit 3.
- R3: A pair is accepted when `in_valid` is high and the block is idle. `out_valid` is high for exactly one cycle, three cycles after the accepting cycle. `in_valid` in the two cycles after an accepted pair is ignored. The outputs change only when a new result is written.
- R4: With control bit 8 = 0 the filter is bypassed: the output is the input sample with only polarity applied, and no history is updated.
- R5: Control bit 0 inverts the left channel and bit 1 the right channel. Inversion is applied after filtering, and it maps -2^(W-1) to 2^(W-1)-1.
- R6: With bit 8 = 1 and bit 7 = 0 (audio mode), each channel computes y = sat(x - x1 + floor(16376*y1 / 2^14)). Here x1 is the previous input and y1 the previous filtered (pre-polarity) output.
- R7: With bits 8 and 7 both 1 (application mode), each channel computes y = sat(floor((16384x - 32768x1 + 16384x2 + a1*y1 + a2*y2) / 2^14)). The coefficients are derived as follows:
  - g = rate_sel[2:1], with 3 treated as 2;
  - c = bits 6:4;
  - e = floor((c+4)*264 / 2^g);
  - r = 16384 - e;
  - a1 = 2r;
  - a2 = -floor(r*r / 2^14).
- R8: Every filtered result is clamped to the range -2^(W-1) to 2^(W-1)-1.
- R9: A control write that changes any of bits 8:4 clears all filter history of both channels at that edge. A write that leaves bits 8:4 equal keeps the history.
- R10: Left and right keep separate filter histories. Each channel's output depends only on its own input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word write value |
| cfg_q | output | 9 | Current control word |
| osr_128 | output | 1 | Stored oversampling-ratio select (1 = 128x) |
| rate_sel | input | 3 | Sample-rate setting; bits 2:1 pick the coefficient group |
| in_valid | input | 1 | Input pair valid |
| in_left | input | W (16) | Left input sample, signed |
| in_right | input | W (16) | Right input sample, signed |
| out_valid | output | 1 | One-cycle pulse marking a finished pair |
| out_left | output | W (16) | Left output sample, signed |
| out_right | output | W (16) | Right output sample, signed |

## Verification
The filter history is only visible through later outputs, so the checks look for its effect there. A wrong history word, a missed clear or a history shared between channels shows up in the very next pair produced in the affected mode. For example, a zero input that follows a clear must produce exactly zero. A wrong coefficient or a wrong group decode spreads through the recursion and shows within a few samples of a step input. Sequencing faults appear at once as a valid pulse in the wrong cycle or an output word changing outside a result write.

// File: rtl/adc_hpf_pkg.sv
package adc_hpf_pkg;

  // Control word layout
  localparam int CFG_W     = 9;
  localparam int B_INV_L   = 0;
  localparam int B_INV_R   = 1;
  localparam int B_OSR     = 3;
  localparam int B_CUT_LO  = 4;
  localparam int B_CUT_HI  = 6;
  localparam int B_APP     = 7;
  localparam int B_EN      = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 9'h100;
  localparam logic [CFG_W-1:0] CFG_WMASK = 9'h1FB;

  // Coefficient format: Q2.14
  localparam int CF_W     = 16;
  localparam int CF_FRAC  = 14;
  localparam int CF_ONE   = 1 << CF_FRAC;
  localparam int CUT_STEP = 264;
  localparam int N_GRP    = 4;
  localparam int N_CODE   = 8;

  typedef logic signed [CF_W-1:0] coef_w_t;

  typedef struct packed {
    coef_w_t b0;
    coef_w_t b1;
    coef_w_t b2;
    coef_w_t a1;
    coef_w_t a2;
  } biquad_coef_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEFT  = 2'd1,
    PH_RIGHT = 2'd2
  } phase_e;

  // Rate setting -> coefficient group (two settings per group, top code folds)
  function automatic logic [1:0] rate_group(input logic [2:0] sel);
    return (sel[2:1] == 2'b11) ? 2'd2 : sel[2:1];
  endfunction

  // Double real pole high-pass: (1 - z^-1)^2 / (1 - r z^-1)^2
  function automatic biquad_coef_t coef_calc(input int grp, input int code);
    biquad_coef_t c;
    int e;
    int r;
    int r2;
    e = ((code + 4) * CUT_STEP) >>> grp;
    r = CF_ONE - e;
    r2 = (r * r) >>> CF_FRAC;
    c.b0 = coef_w_t'(CF_ONE);
    c.b1 = coef_w_t'(-2 * CF_ONE);
    c.b2 = coef_w_t'(CF_ONE);
    c.a1 = coef_w_t'(2 * r);
    c.a2 = coef_w_t'(-r2);
    return c;
  endfunction

endpackage

// File: rtl/adc_hpf_regs.sv
module adc_hpf_regs
  import adc_hpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg,
  output logic             hist_clr
);

  logic [CFG_W-1:0] cfg_r;

  // History is wiped when enable, mode or cutoff code are rewritten to new values
  assign hist_clr = we && (wdata[B_EN:B_CUT_LO] != cfg_r[B_EN:B_CUT_LO]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_r <= CFG_RESET;
    end else if (we) begin
      cfg_r <= wdata & CFG_WMASK;
    end
  end

  assign cfg = cfg_r;

endmodule

// File: rtl/adc_hpf_coef_rom.sv
module adc_hpf_coef_rom
  import adc_hpf_pkg::*;
(
  input  logic [1:0]   grp,
  input  logic [2:0]   code,
  output biquad_coef_t coef
);

  localparam int DEPTH = N_GRP * N_CODE;

  biquad_coef_t table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int GI = ((i / N_CODE) > 2) ? 2 : (i / N_CODE);
    localparam int CI = i % N_CODE;
    assign table_q[i] = coef_calc(GI, CI);
  end

  assign coef = table_q[{grp, code}];

endmodule

// File: rtl/adc_hpf_hist.sv
module adc_hpf_hist #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic                app_mode,
  input  logic signed [W-1:0] x_new,
  input  logic signed [W-1:0] y_new,
  output logic signed [W-1:0] x1,
  output logic signed [W-1:0] x2,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y2
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x1 <= '0;
      x2 <= '0;
      y1 <= '0;
      y2 <= '0;
    end else if (upd) begin
      x1 <= x_new;
      y1 <= y_new;
      if (app_mode) begin
        x2 <= x1;
        y2 <= y1;
      end
    end
  end

endmodule

// File: rtl/adc_hpf_core.sv
module adc_hpf_core
  import adc_hpf_pkg::*;
#(
  parameter int W        = 16,
  parameter int AUD_POLE = 16376
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] x1,
  input  logic signed [W-1:0] x2,
  input  logic signed [W-1:0] y1,
  input  logic signed [W-1:0] y2,
  input  biquad_coef_t        coef,
  input  logic                hpf_en,
  input  logic                app_mode,
  input  logic                inv,
  output logic signed [W-1:0] y_hist,
  output logic signed [W-1:0] y_out
);

  localparam int ACCW = W + CF_W + 3;
  localparam logic signed [ACCW-1:0] HI = ACCW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] LO = -HI - ACCW'(1);
  localparam logic signed [W-1:0]    SMAX = W'(HI);
  localparam logic signed [W-1:0]    SMIN = W'(LO);

  function automatic logic signed [ACCW-1:0] wx(input logic signed [W-1:0] v);
    return ACCW'(v);
  endfunction

  function automatic logic signed [ACCW-1:0] wc(input coef_w_t v);
    return ACCW'(v);
  endfunction

  // First-order DC blocker accumulator, Q14 scaled
  function automatic logic signed [ACCW-1:0] audio_acc(
    input logic signed [W-1:0] xn, input logic signed [W-1:0] xp,
    input logic signed [W-1:0] yp);
    return ((wx(xn) - wx(xp)) <<< CF_FRAC) + wc(coef_w_t'(AUD_POLE)) * wx(yp);
  endfunction

  // Direct-form-I biquad accumulator, Q14 scaled
  function automatic logic signed [ACCW-1:0] biquad_acc(
    input biquad_coef_t c,
    input logic signed [W-1:0] xn, input logic signed [W-1:0] xa,
    input logic signed [W-1:0] xb, input logic signed [W-1:0] ya,
    input logic signed [W-1:0] yb);
    return wc(c.b0) * wx(xn) + wc(c.b1) * wx(xa) + wc(c.b2) * wx(xb)
         + wc(c.a1) * wx(ya) + wc(c.a2) * wx(yb);
  endfunction

  function automatic logic signed [W-1:0] clamp(input logic signed [ACCW-1:0] v);
    if (v > HI) return SMAX;
    if (v < LO) return SMIN;
    return W'(v);
  endfunction

  function automatic logic signed [W-1:0] polarity(input logic signed [W-1:0] v,
                                                   input logic inv_i);
    if (!inv_i) return v;
    if (v == SMIN) return SMAX;
    return -v;
  endfunction

  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] scaled;

  always_comb begin
    acc    = app_mode ? biquad_acc(coef, x, x1, x2, y1, y2) : audio_acc(x, x1, y1);
    scaled = acc >>> CF_FRAC;
    y_hist = hpf_en ? clamp(scaled) : x;
    y_out  = polarity(y_hist, inv);
  end

endmodule

// File: rtl/adc_hpf_cond.sv
module adc_hpf_cond
  import adc_hpf_pkg::*;
#(
  parameter int W        = 16,
  parameter int AUD_POLE = 16376
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_q,
  output logic                osr_128,
  input  logic [2:0]          rate_sel,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_left,
  input  logic signed [W-1:0] in_right,
  output logic                out_valid,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right
);

  localparam int NCH = 2;

  // Control word
  logic [CFG_W-1:0] cfg;
  logic             hist_clr;

  adc_hpf_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .hist_clr (hist_clr)
  );

  assign cfg_q   = cfg;
  assign osr_128 = cfg[B_OSR];

  // Sequencer: accept pair, work left, then right
  phase_e              ph;
  logic signed [W-1:0] cap_l;
  logic signed [W-1:0] cap_r;
  logic signed [W-1:0] out_l_q;
  logic signed [W-1:0] out_r_q;
  logic                out_v_q;
  logic                accept;
  logic                ph_left;
  logic                ph_right;
  logic signed [W-1:0] y_hist;
  logic signed [W-1:0] y_out;

  assign accept   = in_valid && (ph == PH_IDLE);
  assign ph_left  = (ph == PH_LEFT);
  assign ph_right = (ph == PH_RIGHT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cap_l   <= '0;
      cap_r   <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
      out_v_q <= 1'b0;
    end else begin
      out_v_q <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (in_valid) begin
            cap_l <= in_left;
            cap_r <= in_right;
            ph    <= PH_LEFT;
          end
        end
        PH_LEFT: begin
          out_l_q <= y_out;
          ph      <= PH_RIGHT;
        end
        PH_RIGHT: begin
          out_r_q <= y_out;
          out_v_q <= 1'b1;
          ph      <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign out_valid = out_v_q;
  assign out_left  = out_l_q;
  assign out_right = out_r_q;

  // Coefficient table
  biquad_coef_t coef;

  adc_hpf_coef_rom u_rom (
    .grp  (rate_group(rate_sel)),
    .code (cfg[B_CUT_HI:B_CUT_LO]),
    .coef (coef)
  );

  // Per-channel filter history
  logic signed [W-1:0] h_x1 [NCH];
  logic signed [W-1:0] h_x2 [NCH];
  logic signed [W-1:0] h_y1 [NCH];
  logic signed [W-1:0] h_y2 [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic upd;
    assign upd = ((c == 0) ? ph_left : ph_right) && cfg[B_EN];

    adc_hpf_hist #(.W(W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hist_clr),
      .upd      (upd),
      .app_mode (cfg[B_APP]),
      .x_new    ((c == 0) ? cap_l : cap_r),
      .y_new    (y_hist),
      .x1       (h_x1[c]),
      .x2       (h_x2[c]),
      .y1       (h_y1[c]),
      .y2       (h_y2[c])
    );
  end

  // Shared arithmetic unit, channel picked by phase
  logic sel;
  assign sel = ph_right;

  adc_hpf_core #(.W(W), .AUD_POLE(AUD_POLE)) u_core (
    .x        (sel ? cap_r : cap_l),
    .x1       (h_x1[sel]),
    .x2       (h_x2[sel]),
    .y1       (h_y1[sel]),
    .y2       (h_y2[sel]),
    .coef     (coef),
    .hpf_en   (cfg[B_EN]),
    .app_mode (cfg[B_APP]),
    .inv      (sel ? cfg[B_INV_R] : cfg[B_INV_L]),
    .y_hist   (y_hist),
    .y_out    (y_out)
  );

  // Event wire for the checker: every history word is zero
  logic hist_zero;
  always_comb begin
    hist_zero = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (h_x1[c] != '0 || h_x2[c] != '0 || h_y1[c] != '0 || h_y2[c] != '0)
        hist_zero = 1'b0;
    end
  end

endmodule

// File: rtl/adc_hpf_cond_chk.sv
module adc_hpf_cond_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [8:0]          cfg_wdata,
  input logic [8:0]          cfg_q,
  input logic                osr_128,
  input logic                out_valid,
  input logic signed [W-1:0] out_left,
  input logic                accept,
  input logic                ph_left,
  input logic                hist_clr,
  input logic                hist_zero
);

  // R2: control word only moves on a write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  // R2: oversampling output follows the written bit
  p_osr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (osr_128 == $past(cfg_wdata[3])));

  // R3: fixed latency from acceptance to valid pulse
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##3 out_valid);

  // R3: valid is a single-cycle pulse
  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3: left output word changes only in the left work cycle
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_left |=> $stable(out_left));

  // R9: a clearing write leaves the whole history at zero
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> hist_zero);

endmodule

bind adc_hpf_cond adc_hpf_cond_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_q     (cfg_q),
  .osr_128   (osr_128),
  .out_valid (out_valid),
  .out_left  (out_left),
  .accept    (accept),
  .ph_left   (ph_left),
  .hist_clr  (hist_clr),
  .hist_zero (hist_zero)
);

// File: tb/adc_hpf_cond_tb_top.sv
module adc_hpf_cond_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_we = 1'b0;
  logic [8:0]          cfg_wdata = '0;
  logic [8:0]          cfg_q;
  logic                osr_128;
  logic [2:0]          rate_sel = 3'b000;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_left = '0;
  logic signed [W-1:0] in_right = '0;
  logic                out_valid;
  logic signed [W-1:0] out_left;
  logic signed [W-1:0] out_right;

  always #2.5 clk = ~clk;

  adc_hpf_cond #(.W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .osr_128   (osr_128),
    .rate_sel  (rate_sel),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model state
  logic [8:0] mcfg = 9'h100;
  longint mx1 [2];
  longint mx2 [2];
  longint my1 [2];
  longint my2 [2];

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint msat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint mpol(input longint v, input bit inv);
    if (!inv) return v;
    return msat(-v);
  endfunction

  function automatic void mclear();
    for (int c = 0; c < 2; c++) begin
      mx1[c] = 0; mx2[c] = 0; my1[c] = 0; my2[c] = 0;
    end
  endfunction

  function automatic longint mstep(input int ch, input longint x);
    longint f;
    longint g, e, r, a1, a2, acc;
    if (!mcfg[8]) begin
      f = x;
    end else if (!mcfg[7]) begin
      f = msat(x - mx1[ch] + ((longint'(16376) * my1[ch]) >>> 14));
      mx1[ch] = x;
      my1[ch] = f;
    end else begin
      g = (rate_sel[2:1] == 2'b11) ? 2 : longint'(rate_sel[2:1]);
      e = ((longint'(mcfg[6:4]) + 4) * 264) >>> g;
      r = 16384 - e;
      a1 = 2 * r;
      a2 = -((r * r) >>> 14);
      acc = 16384 * x - 32768 * mx1[ch] + 16384 * mx2[ch] + a1 * my1[ch] + a2 * my2[ch];
      f = msat(acc >>> 14);
      mx2[ch] = mx1[ch]; mx1[ch] = x;
      my2[ch] = my1[ch]; my1[ch] = f;
    end
    return mpol(f, mcfg[ch]);
  endfunction

  task automatic wr_cfg(input logic [8:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (v[8:4] != mcfg[8:4]) mclear();
    mcfg = v & 9'h1FB;
  endtask

  // Send one pair and compare against the model three cycles later
  task automatic send(input longint l, input longint r, input string req);
    longint el, er;
    @(negedge clk);
    in_valid = 1'b1;
    in_left = W'(l);
    in_right = W'(r);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    el = mstep(0, l);
    er = mstep(1, r);
    chk({req, " valid"}, longint'(out_valid), 1);
    chk({req, " left"}, longint'(out_left), el);
    chk({req, " right"}, longint'(out_right), er);
  endtask

  task automatic t_reset();
    chk("R1 cfg_q", longint'(cfg_q), 'h100);
    chk("R1 osr_128", longint'(osr_128), 0);
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 out_left", longint'(out_left), 0);
    chk("R1 out_right", longint'(out_right), 0);
  endtask

  task automatic t_register();
    wr_cfg(9'h1FF);
    chk("R2 bit2 masked", longint'(cfg_q), 'h1FB);
    chk("R2 osr set", longint'(osr_128), 1);
    wr_cfg(9'h0F4);
    chk("R2 write", longint'(cfg_q), 'h0F0);
    chk("R2 osr clear", longint'(osr_128), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 hold", longint'(cfg_q), 'h0F0);
  endtask

  task automatic t_bypass();
    wr_cfg(9'h003);
    send(1000, -2000, "R4 R5 both inverted");
    send(-32768, 32767, "R5 negate extremes");
    wr_cfg(9'h001);
    send(-32768, -32768, "R5 left only");
    wr_cfg(9'h000);
    send(123, -456, "R4 pass through");
    send(-32768, 5, "R4 no history");
  endtask

  task automatic t_latency();
    wr_cfg(9'h000);
    @(negedge clk);
    in_valid = 1'b1;
    in_left = 16'sd300;
    in_right = -16'sd7;
    @(negedge clk);
    chk("R3 no valid at +1", longint'(out_valid), 0);
    in_left = 16'sd999;
    in_right = 16'sd999;
    @(negedge clk);
    chk("R3 no valid at +2", longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 valid at +3", longint'(out_valid), 1);
    chk("R3 left data", longint'(out_left), 300);
    chk("R3 right data", longint'(out_right), -7);
    for (int k = 4; k < 8; k++) begin
      @(negedge clk);
      chk("R3 busy input ignored", longint'(out_valid), 0);
    end
    chk("R3 outputs held", longint'(out_left), 300);
  endtask

  task automatic t_audio();
    wr_cfg(9'h100);
    send(10000, -5000, "R6 step start");
    for (int k = 0; k < 5; k++) send(10000, 0, "R6 R10 hold");
    send(-2000, 3000, "R6 R10 change");
    send(0, 0, "R6 decay");
  endtask

  task automatic t_clear();
    wr_cfg(9'h100);
    send(8000, -8000, "R9 prime");
    send(8000, -8000, "R9 prime");
    wr_cfg(9'h101);
    send(0, 0, "R9 polarity write keeps history");
    wr_cfg(9'h111);
    send(0, 0, "R9 code write clears");
    chk("R9 zero after clear left", longint'(out_left), 0);
    chk("R9 zero after clear right", longint'(out_right), 0);
  endtask

  task automatic t_app();
    logic [2:0] rates [4] = '{3'b000, 3'b011, 3'b101, 3'b111};
    int codes [3] = '{0, 3, 7};
    for (int ri = 0; ri < 4; ri++) begin
      for (int ci = 0; ci < 3; ci++) begin
        wr_cfg(9'h180 | (9'(codes[ci]) << 4));
        @(negedge clk);
        rate_sel = rates[ri];
        send(8000, -12000, "R7 step");
        send(8000, -12000, "R7 step");
        send(8000, 4000, "R7 R10 step");
        send(-3000, 4000, "R7 change");
        send(0, 0, "R7 settle");
        send(12000, -1, "R7 jump");
      end
    end
    rate_sel = 3'b000;
  endtask

  task automatic t_sat();
    wr_cfg(9'h100);
    send(32767, -32768, "R8 audio first");
    send(-32768, 32767, "R8 audio swing");
    send(32767, -32768, "R8 audio swing");
    wr_cfg(9'h1F0);
    for (int k = 0; k < 4; k++) begin
      send(32767, -32768, "R8 app swing");
      send(-32768, 32767, "R8 app swing");
    end
    wr_cfg(9'h1F3);
    send(32767, -32768, "R8 R5 app inverted");
  endtask

  initial begin
    mclear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register();
    t_bypass();
    t_latency();
    t_audio();
    t_clear();
    t_app();
    t_sat();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule